// File: doc/BRIEF.md
# Snoop and DVM Port Enable Controller

This block holds, for each slave port of a coherent interconnect, a small control setting that says whether the port takes part in snoop traffic and whether it receives distributed virtual memory (DVM) broadcasts. Software sets these through a simple memory-mapped register bus. Each port has its own register window, with the control register at offset 0 of that window. Window 0 holds a global status register at offset 0xC. The first two port windows belong to the full-coherency ports and the remaining three to the I/O-coherent lite ports. The default configuration has five ports in total.

A new setting reaches the port's enable outputs on the next clock. Downstream logic still needs time to drain or start snoop activity, so any write that changes a port's setting opens a handshake. The block raises that port's change request and holds it until the port's acknowledge input arrives. The status register reads 1 while any port's change request is outstanding. A power-management sequence writes the control register and then polls status until it reads 0. After that, every port is known to be in its new state.

Top module: `snoop_port_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every port's snoop and DVM enables are 0, no change request is raised, the status register reads 0 and every control register reads 0.
- R2: A write to port p's window (address (p+1)*0x1000, offset 0) stores data bits [1:0]. Bit 0 drives snoop_en[p] and bit 1 drives dvm_en[p], both from the next clock. Writing 0 removes both enables, so a disabled port neither accepts snoops nor gets DVM broadcasts.
- R3: Reading a port's control register returns the last stored value in bits [1:0]. Bits [31:2] read as zero and are discarded on write.
- R4: A control write whose bits [1:0] differ from the stored value sets chg_req[p] from the next clock. Status bit 0 then reads 1.
- R5: A control write whose bits [1:0] equal the stored value leaves chg_req[p] unchanged.
- R6: chg_req[p] clears on the clock after chg_ack[p] is high. Status bit 0 reads 0 only when no chg_req bit is set.
- R7: chg_ack[p] has no effect while chg_req[p] is low.
- R8: Writes to any address other than a port control register change no port state. This includes the status register, other offsets inside a port window and unmapped windows. Reads of such addresses other than status return 0.
- R9: A changing write to port p in the same cycle as chg_ack[p] leaves chg_req[p] set.
- R10: The status register (address 0xC) reads 0 in bits [31:1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, valid while a read is selected |
| snoop_en | output | 5 | Per-port snoop acceptance enable |
| dvm_en | output | 5 | Per-port DVM broadcast enable |
| chg_req | output | 5 | Per-port outstanding change request |
| chg_ack | input | 5 | Per-port downstream completion acknowledge |

## Verification
A wrong stored setting shows on snoop_en or dvm_en one clock after the write and again on any register read. A wrong pending flag shows at once on chg_req and on the status read. The pending flag could be set when it should not be, dropped early, or kept after the acknowledge. The reference model tracks each port's setting and pending state cycle by cycle. The outputs are compared on every clock, so any divergence is caught in the first cycle it appears. The stimulus covers several cases: equal-value writes, acknowledges with nothing pending, stray addresses, and a write that coincides with an acknowledge. These are the cases where a faulty flag would otherwise go unseen.

// File: rtl/snpctl_pkg.sv
// Shared definitions for the snoop port enable controller.
// Assumes a byte-addressed register bus with one window per port.
package snpctl_pkg;
    // Register offsets inside a window (window 0 holds status).
    localparam int CTRL_OFS = 0;
    localparam int STAT_OFS = 12;

    // Per-port control setting: bit 0 snoop, bit 1 DVM.
    typedef enum logic [1:0] {
        PM_OFF   = 2'b00,
        PM_SNOOP = 2'b01,
        PM_DVM   = 2'b10,
        PM_BOTH  = 2'b11
    } port_mode_e;
endpackage

// File: rtl/snpctl_decode.sv
// Address decoder: turns a bus address into one-hot port control hits
// and a status hit. Assumes NUM_PORTS+1 windows fit in the upper address bits.
module snpctl_decode #(
    parameter int NUM_PORTS = 5,
    parameter int ADDR_W    = 16,
    parameter int WIN_BITS  = 12
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_PORTS-1:0] port_hit,
    output logic                 stat_hit
);
    import snpctl_pkg::*;

    localparam int WIN_W = ADDR_W - WIN_BITS;

    logic [WIN_W-1:0]    win;
    logic [WIN_BITS-1:0] ofs;

    assign win = addr[ADDR_W-1:WIN_BITS];
    assign ofs = addr[WIN_BITS-1:0];

    // Status register lives in window 0.
    assign stat_hit = (win == '0) && (ofs == WIN_BITS'(STAT_OFS));

    // Port p owns window p+1; its control register sits at offset 0.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hit
        assign port_hit[p] = (win == WIN_W'(p + 1)) && (ofs == WIN_BITS'(CTRL_OFS));
    end
endmodule

// File: rtl/snpctl_port.sv
// One port's control register and change handshake. A write that alters
// the setting raises req until ack arrives. Assumes ack is a level
// sampled each clock and that a new change restarts the wait.
module snpctl_port (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_val,
    input  logic       ack,
    output logic [1:0] mode,
    output logic       req
);
    import snpctl_pkg::*;

    port_mode_e mode_q;
    logic       change;

    assign change = wr_en && (port_mode_e'(wr_val) != mode_q);
    assign mode   = mode_q;

    // Hold the latest written setting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= PM_OFF;
        else if (change)
            mode_q <= port_mode_e'(wr_val);
    end

    // Track whether a change still awaits its acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req <= 1'b0;
        else if (change)
            req <= 1'b1;
        else if (ack)
            req <= 1'b0;
    end

    // R4, R9: a changing write always leaves a request open.
    a_r4_change_raises_req: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_val != mode)) |=> req);

    // R6: acknowledge without a new change closes the request.
    a_r6_ack_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !(wr_en && (wr_val != mode))) |=> !req);

    // R5, R7: equal write or idle ack leaves the request as it was.
    a_r5_equal_write_keeps_req: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_val == mode) && !ack) |=> (req == $past(req)));

    // R2: the setting only moves on a write to this port.
    a_r2_mode_stable_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mode));
endmodule

// File: rtl/snpctl_status.sv
// Busy aggregation and read-data mux. Status bit 0 is the OR of all
// outstanding requests; port reads return the stored 2-bit setting.
module snpctl_status #(
    parameter int NUM_PORTS = 5,
    parameter int DATA_W    = 32
) (
    input  logic                      rd_en,
    input  logic [NUM_PORTS-1:0]      port_hit,
    input  logic                      stat_hit,
    input  logic [NUM_PORTS-1:0][1:0] modes,
    input  logic [NUM_PORTS-1:0]      pend,
    output logic                      busy,
    output logic [DATA_W-1:0]         rdata
);
    assign busy = |pend;

    // Select read data for the addressed register, zero elsewhere.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (stat_hit)
                rdata[0] = busy;
            for (int p = 0; p < NUM_PORTS; p++)
                if (port_hit[p])
                    rdata[1:0] = modes[p];
        end
    end
endmodule

// File: rtl/snoop_port_ctrl.sv
// Top of the snoop port enable controller. Full-coherency ports take the
// first windows, lite ports follow; both classes behave alike here.
// Assumes single-cycle register accesses with combinational read data.
module snoop_port_ctrl #(
    parameter int NUM_FULL = 2,
    parameter int NUM_LITE = 3,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int WIN_BITS = 12,
    localparam int NP      = NUM_FULL + NUM_LITE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NP-1:0]     snoop_en,
    output logic [NP-1:0]     dvm_en,
    output logic [NP-1:0]     chg_req,
    input  logic [NP-1:0]     chg_ack
);
    logic [NP-1:0]      port_hit;
    logic               stat_hit;
    logic [NP-1:0][1:0] modes;
    logic               busy;
    logic               wr_cyc;
    logic               rd_cyc;
    logic               unused_wdata;

    assign wr_cyc       = bus_sel && bus_wr;
    assign rd_cyc       = bus_sel && !bus_wr;
    assign unused_wdata = ^bus_wdata[DATA_W-1:2];

    snpctl_decode #(
        .NUM_PORTS (NP),
        .ADDR_W    (ADDR_W),
        .WIN_BITS  (WIN_BITS)
    ) u_decode (
        .addr     (bus_addr),
        .port_hit (port_hit),
        .stat_hit (stat_hit)
    );

    for (genvar p = 0; p < NP; p++) begin : g_port
        snpctl_port u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_cyc && port_hit[p]),
            .wr_val (bus_wdata[1:0]),
            .ack    (chg_ack[p]),
            .mode   (modes[p]),
            .req    (chg_req[p])
        );
        assign snoop_en[p] = modes[p][0];
        assign dvm_en[p]   = modes[p][1];
    end

    snpctl_status #(
        .NUM_PORTS (NP),
        .DATA_W    (DATA_W)
    ) u_status (
        .rd_en    (rd_cyc),
        .port_hit (port_hit),
        .stat_hit (stat_hit),
        .modes    (modes),
        .pend     (chg_req),
        .busy     (busy),
        .rdata    (bus_rdata)
    );

    // R8: writes that hit no port control register leave every enable alone.
    a_r8_stray_write_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cyc && (port_hit == '0)) |=> ($stable(snoop_en) && $stable(dvm_en)));

    // R1: reset leaves all enables and requests low.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (snoop_en == '0 && dvm_en == '0 && chg_req == '0));
endmodule

// File: tb/snoop_port_ctrl_bench.sv
// Bench: behavioural reference model updated on every rising edge and
// compared against the outputs on every falling edge.
module snoop_port_ctrl_bench;
    localparam int NP = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] snoop_en, dvm_en, chg_req;
    logic [NP-1:0] chg_ack = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_ctrl [NP];
    bit m_pend [NP];

    always #4 clk = ~clk;

    snoop_port_ctrl u_snoop_port_ctrl (
        .clk (clk), .rst_n (rst_n), .bus_sel (bus_sel), .bus_wr (bus_wr),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .snoop_en (snoop_en), .dvm_en (dvm_en), .chg_req (chg_req),
        .chg_ack (chg_ack)
    );

    // Reference model (R1, R2, R4-R9).
    always @(posedge clk) begin
        for (int p = 0; p < NP; p++) begin
            if (!rst_n) begin
                m_ctrl[p] = 0;
                m_pend[p] = 0;
            end else begin
                int nv;
                bit hit;
                nv  = int'(bus_wdata & 32'h3);
                hit = bus_sel && bus_wr && (bus_addr == 16'((p + 1) * 4096));
                if (hit && nv != m_ctrl[p]) begin
                    m_ctrl[p] = nv;
                    m_pend[p] = 1;
                end else if (chg_ack[p]) begin
                    m_pend[p] = 0;
                end
            end
        end
    end

    function automatic bit any_pend();
        bit b = 0;
        for (int p = 0; p < NP; p++) b |= m_pend[p];
        return b;
    endfunction

    function automatic logic [31:0] exp_read(input logic [15:0] a);
        if (a == 16'h000C) return {31'b0, any_pend()};
        for (int p = 0; p < NP; p++)
            if (a == 16'((p + 1) * 4096)) return 32'(m_ctrl[p]);
        return 32'h0;
    endfunction

    // Per-cycle output comparison.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < NP; p++) begin
                checks++;
                if (snoop_en[p] !== m_ctrl[p][0] || dvm_en[p] !== m_ctrl[p][1]) begin
                    errors++;
                    $display("FAIL R2 port %0d enables actual snoop=%b dvm=%b expected %0d",
                             p, snoop_en[p], dvm_en[p], m_ctrl[p]);
                end
                checks++;
                if (chg_req[p] !== m_pend[p]) begin
                    errors++;
                    $display("FAIL R4/R6 port %0d chg_req actual %b expected %b",
                             p, chg_req[p], m_pend[p]);
                end
            end
        end
    end

    task automatic do_write(input logic [15:0] a, input logic [31:0] d, input logic [NP-1:0] ack);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; chg_ack = ack;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; chg_ack = '0;
    endtask

    task automatic do_ack(input logic [NP-1:0] ack);
        @(negedge clk);
        chg_ack = ack;
        @(negedge clk);
        chg_ack = '0;
    endtask

    task automatic do_read(input logic [15:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        e = exp_read(a);
        checks++;
        if (bus_rdata !== e) begin
            errors++;
            $display("FAIL %s read 0x%h actual 0x%h expected 0x%h", tag, a, bus_rdata, e);
        end
        @(negedge clk);
        bus_sel = 0;
    endtask

    // Watchdog: a hang counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        for (int p = 0; p < NP; p++) do_read(16'((p + 1) * 4096), "R1");
        do_read(16'h000C, "R1");
        // R2, R4: enable both on port 0
        do_write(16'h1000, 32'h3, '0);
        do_read(16'h000C, "R4");
        // R3, R5: equal value with upper bits set
        do_write(16'h1000, 32'hFFFF_FFFF, '0);
        do_read(16'h1000, "R3");
        // R6: acknowledge closes it
        do_ack(5'b00001);
        do_read(16'h000C, "R6");
        // R2: disable port 0 again, then ack
        do_write(16'h1000, 32'h0, '0);
        do_ack(5'b00001);
        // R6: two ports outstanding, status holds until both done
        do_write(16'h2000, 32'h1, '0);
        do_write(16'h3000, 32'h2, '0);
        do_ack(5'b00010);
        do_read(16'h000C, "R6");
        do_ack(5'b00100);
        do_read(16'h000C, "R6");
        do_read(16'h3000, "R3");
        // R7: idle acknowledge ignored
        do_ack(5'b01000);
        do_read(16'h000C, "R7");
        // R9: changing write together with ack keeps request
        do_write(16'h5000, 32'h3, '0);
        do_write(16'h5000, 32'h1, 5'b10000);
        do_read(16'h000C, "R9");
        do_ack(5'b10000);
        // R8: stray writes
        do_write(16'h5004, 32'h0, '0);
        do_write(16'h7000, 32'h3, '0);
        do_write(16'h000C, 32'h3, '0);
        do_write(16'h0000, 32'h3, '0);
        do_read(16'h5000, "R8");
        do_read(16'h7000, "R8");
        do_read(16'h5004, "R8");
        // R10: status upper bits zero while busy
        do_write(16'h4000, 32'h3, '0);
        do_read(16'h000C, "R10");
        do_ack(5'b01000);
        do_read(16'h4000, "R3");
        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule